// File: doc/BRIEF.md
# ECC Page Error Report Aggregator

This block sits beside a BCH decoder during a page read. It gathers the decoder's result for each codeword packet and builds one 32-bit summary word for the whole page. A page opens with a start strobe. Each packet then delivers one result strobe, which carries a corrected-bit count, a decode-failure flag and an erased indication. The page closes with an end strobe.

The first packet of a page gets its own count field and its own success bit. All later packets fold into one shared field, which holds the largest count seen so far, and one shared success bit, which any single failure clears. A separate erased-page flag tells software to ignore the word, because erased pages are not checked for bitflips here.

One cycle after the end strobe the block gives a one-cycle valid pulse. The word and the flag then hold their values until the next page opens.

Top module: `ecc_report_agg`

## Requirements
- R1: After reset the report word is 0x00008080, the erased flag is 0 and the valid pulse is low.
- R2: A page-start strobe clears both count fields to 0, sets bits 7 and 15 to 1 and clears the erased flag. The word reads 0x00008080 in the following cycle.
- R3: Bits [5:0] hold the corrected count of the first packet received after page start.
- R4: Any count above 63 is recorded as 63, in both count fields.
- R5: Bits [13:8] hold the maximum, not the sum, of the counts of the second and later packets of the page.
- R6: Bit 7 is 1 when the first packet decoded successfully and 0 when its fail flag was set.
- R7: Bit 15 is cleared by a fail flag on any packet after the first, and it stays clear until the next page start.
- R8: At page end the erased flag becomes 1 only when at least one packet arrived and every packet of the page reported erased. Otherwise it becomes 0.
- R9: The valid pulse is high for exactly the one cycle after an end strobe that falls inside a page. After that, packet and end strobes are ignored until the next start strobe, and the word and the erased flag hold their values.
- R10: Bits 6, 14 and [31:16] of the report word are always 0.
- R11: When strobes coincide, start wins over end, and end wins over a packet result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pageStart | input | 1 | Opens a page and presets the report |
| pktValid | input | 1 | One packet result is present this cycle |
| pktErrCnt | input | IN_W | Corrected-bit count of the packet |
| pktFail | input | 1 | The packet could not be decoded |
| pktErased | input | 1 | The packet was read as erased |
| pageEnd | input | 1 | Closes the page |
| reportWord | output | 32 | Page error report |
| pageEmpty | output | 1 | The page was erased |
| reportValid | output | 1 | One-cycle pulse after the page closes |

## Verification
The pages used are these:
- A clean page with mixed counts. It separates a maximum from a sum and from a last-value field.
- A page with failures and counts over 63. It exercises saturation and shows which success bit each failure clears.
- A fully erased page, a partly erased page and a page with no packets. Together they pin down when the erased flag may rise.
- A stray packet and a stray end strobe after the close. They must leave the held word unchanged.
- Back-to-back pages. They show that the preset at page start happens in the cycle right after a close.
- Coincident strobes. They confirm the priority order.

// File: rtl/ecc_report_pkg.sv
package ecc_report_pkg;
  typedef struct packed {
    logic clearAll;
    logic firstPkt;
    logic laterPkt;
    logic finish;
  } aggStrobe_t;
endpackage

// File: rtl/ecc_report_ctrl.sv
module ecc_report_ctrl
  import ecc_report_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pageStart,
  input  logic       pktValid,
  input  logic       pageEnd,
  output aggStrobe_t strb,
  output logic       reportValid
);
  logic inPage;
  logic firstPending;

  // Priority: start, then end, then packet result.
  always_comb begin
    strb = '0;
    if (pageStart) begin
      strb.clearAll = 1'b1;
    end else if (inPage) begin
      if (pageEnd) begin
        strb.finish = 1'b1;
      end else if (pktValid) begin
        strb.firstPkt = firstPending;
        strb.laterPkt = !firstPending;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inPage       <= 1'b0;
      firstPending <= 1'b0;
      reportValid  <= 1'b0;
    end else begin
      reportValid <= strb.finish;
      if (strb.clearAll) begin
        inPage       <= 1'b1;
        firstPending <= 1'b1;
      end else if (strb.finish) begin
        inPage <= 1'b0;
      end else if (strb.firstPkt) begin
        firstPending <= 1'b0;
      end
    end
  end

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    reportValid |=> !reportValid);

  // R9
  valid_after_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reportValid) |-> $past(pageEnd));
endmodule

// File: rtl/ecc_report_dp.sv
module ecc_report_dp
  import ecc_report_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int CNT_W = 6
) (
  input  logic            clk,
  input  logic            rstN,
  input  aggStrobe_t      strb,
  input  logic [IN_W-1:0] pktErrCnt,
  input  logic            pktFail,
  input  logic            pktErased,
  output logic [31:0]     reportWord,
  output logic            pageEmpty
);
  localparam int CNT_MAX = (1 << CNT_W) - 1;
  localparam int OK0_BIT = 7;
  localparam int N_BASE  = 8;
  localparam int OKN_BIT = 15;

  logic [CNT_W-1:0] cnt0;
  logic [CNT_W-1:0] cntN;
  logic [CNT_W-1:0] satCnt;
  logic             ok0;
  logic             okN;
  logic             allErased;
  logic             anyPkt;

  always_comb begin
    if (pktErrCnt > IN_W'(CNT_MAX)) satCnt = CNT_W'(CNT_MAX);
    else                            satCnt = pktErrCnt[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt0      <= '0;
      cntN      <= '0;
      ok0       <= 1'b1;
      okN       <= 1'b1;
      allErased <= 1'b1;
      anyPkt    <= 1'b0;
      pageEmpty <= 1'b0;
    end else if (strb.clearAll) begin
      cnt0      <= '0;
      cntN      <= '0;
      ok0       <= 1'b1;
      okN       <= 1'b1;
      allErased <= 1'b1;
      anyPkt    <= 1'b0;
      pageEmpty <= 1'b0;
    end else if (strb.finish) begin
      pageEmpty <= allErased && anyPkt;
    end else if (strb.firstPkt || strb.laterPkt) begin
      anyPkt    <= 1'b1;
      allErased <= allErased && pktErased;
      if (strb.firstPkt) begin
        cnt0 <= satCnt;
        ok0  <= !pktFail;
      end else begin
        if (satCnt > cntN) cntN <= satCnt;
        okN <= okN && !pktFail;
      end
    end
  end

  always_comb begin
    reportWord                         = '0;
    reportWord[CNT_W-1:0]              = cnt0;
    reportWord[OK0_BIT]                = ok0;
    reportWord[N_BASE+CNT_W-1:N_BASE]  = cntN;
    reportWord[OKN_BIT]                = okN;
  end

  // R7
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!okN && !strb.clearAll) |=> !okN);

  // R5
  max_monotone_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clearAll |=> cntN >= $past(cntN));

  // R8
  empty_at_finish_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pageEmpty) |-> $past(strb.finish));
endmodule

// File: rtl/ecc_report_agg.sv
module ecc_report_agg
  import ecc_report_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int CNT_W = 6
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            pageStart,
  input  logic            pktValid,
  input  logic [IN_W-1:0] pktErrCnt,
  input  logic            pktFail,
  input  logic            pktErased,
  input  logic            pageEnd,
  output logic [31:0]     reportWord,
  output logic            pageEmpty,
  output logic            reportValid
);
  aggStrobe_t strb;

  ecc_report_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .pageStart(pageStart), .pktValid(pktValid),
    .pageEnd(pageEnd), .strb(strb), .reportValid(reportValid)
  );

  ecc_report_dp #(.IN_W(IN_W), .CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pktErrCnt(pktErrCnt),
    .pktFail(pktFail), .pktErased(pktErased),
    .reportWord(reportWord), .pageEmpty(pageEmpty)
  );

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.clearAll || strb.firstPkt || strb.laterPkt) |=> $stable(reportWord));
endmodule

// File: tb/test_ecc_report_agg.sv
module test_ecc_report_agg;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pageStart = 1'b0, pktValid = 1'b0, pktFail = 1'b0;
  logic        pktErased = 1'b0, pageEnd = 1'b0;
  logic [7:0]  pktErrCnt = '0;
  logic [31:0] reportWord;
  logic        pageEmpty, reportValid;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  ecc_report_agg i_ecc_report_agg (
    .clk(clk), .rstN(rstN), .pageStart(pageStart), .pktValid(pktValid),
    .pktErrCnt(pktErrCnt), .pktFail(pktFail), .pktErased(pktErased),
    .pageEnd(pageEnd), .reportWord(reportWord), .pageEmpty(pageEmpty),
    .reportValid(reportValid)
  );

  // Behavioural reference model
  int m0 = 0, mN = 0, c = 0;
  bit ok0 = 1, okN = 1, allEr = 1, anyP = 0, inPage = 0, first = 0;
  bit mEmpty = 0, mValid = 0;

  always @(posedge clk) if (rstN) begin
    mValid = 0;
    if (pageStart) begin
      m0 = 0; mN = 0; ok0 = 1; okN = 1; allEr = 1; anyP = 0;
      mEmpty = 0; inPage = 1; first = 1;
    end else if (inPage) begin
      if (pageEnd) begin
        mValid = 1; mEmpty = allEr && anyP; inPage = 0;
      end else if (pktValid) begin
        c = (pktErrCnt > 63) ? 63 : int'(pktErrCnt);
        anyP = 1; allEr = allEr && pktErased;
        if (first) begin m0 = c; ok0 = !pktFail; first = 0; end
        else begin if (c > mN) mN = c; okN = okN && !pktFail; end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rstN) begin
    chk("R3 pkt0 count", 32'(reportWord[5:0]), 32'(m0));
    chk("R5 later max", 32'(reportWord[13:8]), 32'(mN));
    chk("R6 pkt0 ok", 32'(reportWord[7]), 32'(ok0));
    chk("R7 later ok", 32'(reportWord[15]), 32'(okN));
    chk("R10 zero bits", {reportWord[31:16], 8'h0, reportWord[14], 6'h0, reportWord[6]}, 32'h0);
    chk("R8 empty", 32'(pageEmpty), 32'(mEmpty));
    chk("R9 valid", 32'(reportValid), 32'(mValid));
  end

  task automatic drive(bit ps, bit pv, int cnt, bit f, bit e, bit pe);
    @(negedge clk);
    pageStart = ps; pktValid = pv; pktErrCnt = 8'(cnt);
    pktFail = f; pktErased = e; pageEnd = pe;
  endtask

  task automatic idle(); drive(0, 0, 0, 0, 0, 0); endtask
  task automatic pkt(int cnt, bit f, bit e); drive(0, 1, cnt, f, e, 0); endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset word", reportWord, 32'h0000_8080);
    chk("R1 reset empty", 32'(pageEmpty), 0);
    chk("R1 reset valid", 32'(reportValid), 0);
    rstN = 1'b1;

    // Page A: clean, mixed counts
    drive(1, 0, 0, 0, 0, 0);
    idle();
    chk("R2 preset", reportWord, 32'h0000_8080);
    pkt(5, 0, 0); pkt(3, 0, 0); pkt(10, 0, 0); pkt(7, 0, 0);
    drive(0, 0, 0, 0, 0, 1);
    idle();
    chk("R5 max not sum", reportWord, 32'h0000_8A85);
    chk("R9 pulse", 32'(reportValid), 1);
    // stray strobes after close
    pkt(40, 1, 0); drive(0, 0, 0, 0, 0, 1); idle(); idle();
    chk("R9 ignored after close", reportWord, 32'h0000_8A85);

    // Page B: failures and saturation
    drive(1, 0, 0, 0, 0, 0);
    pkt(70, 1, 0);
    idle();
    chk("R4 sat pkt0", reportWord & 32'hFF, 32'h3F);
    pkt(2, 1, 0); pkt(200, 0, 0); pkt(1, 0, 0);
    drive(0, 0, 0, 0, 0, 1);
    idle();
    chk("R4 R7 sat and fail", reportWord, 32'h0000_3F3F);

    // Page C: all erased, back to back with previous close
    drive(1, 0, 0, 0, 0, 0);
    pkt(0, 0, 1); pkt(0, 0, 1); pkt(0, 0, 1);
    drive(0, 0, 0, 0, 0, 1);
    idle();
    chk("R8 all erased", 32'(pageEmpty), 1);

    // Page D: partly erased
    drive(1, 0, 0, 0, 0, 0);
    pkt(0, 0, 1); pkt(4, 0, 0);
    drive(0, 0, 0, 0, 0, 1);
    drive(1, 0, 0, 0, 0, 0);
    chk("R8 partly erased", 32'(pageEmpty), 0);

    // Page E: no packets
    drive(0, 0, 0, 0, 0, 1);
    idle();
    chk("R8 no packets", 32'(pageEmpty), 0);

    // Priority: start with end and packet
    drive(1, 1, 9, 1, 0, 1);
    idle();
    chk("R11 start wins", reportWord, 32'h0000_8080);
    drive(0, 1, 9, 1, 0, 1);
    idle();
    chk("R11 end wins", reportWord, 32'h0000_8080);
    chk("R11 end pulse", 32'(reportValid), 1);
    idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule